// File: doc/BRIEF.md
# Fast Link Pulse Burst Generator

This block turns one 16-bit link code word into a single burst of fast link pulses on a one-bit line. A burst has 33 equally spaced pulse slots. Slots 1, 3, 5, up to 33, carry timing pulses that are always sent. The 16 slots between them carry the word, one bit per slot: a pulse means 1 and a gap means 0. The least significant bit goes first, in slot 2.

A request made while the block is idle latches the code word and starts the burst. A busy flag stays high until the last timing pulse has ended, and a one-cycle done flag then marks the end of the burst. The slot spacing and the pulse width are both parameters given in clock cycles. The defaults give 62.5 µs and 100 ns at 100 MHz, and a simulation can use much shorter values. The line driver and the repeating of bursts belong to the surrounding logic.

Top module: `flp_burst_gen`

## Requirements
- R1: After reset, and while no burst is running, pulse_out, busy and burst_done are all 0.
- R2: A send_req sampled high while busy is 0 latches code_word. busy is 1 from the next cycle on, and the slot 1 pulse starts one cycle after that.
- R3: Odd slots 1 to 33 always carry a pulse. Slot k starts SLOT_TICKS cycles after slot k-1.
- R4: Even slot 2k+2 carries bit k of the latched word (k = 0 for the least significant bit). A pulse is sent in that slot only if the bit is 1.
- R5: Every pulse is high for exactly PULSE_CYCLES consecutive cycles.
- R6: While busy is 1, send_req is ignored and changes on code_word have no effect on the burst in progress.
- R7: busy stays 1 until the slot 33 pulse has ended. It falls on the same clock edge that pulse_out falls and burst_done rises.
- R8: burst_done is high for exactly one cycle per burst.
- R9: A send_req in the cycle where burst_done is high starts a new burst right away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Request to send one burst |
| code_word | input | 16 | Link code word, latched when a request is accepted |
| pulse_out | output | 1 | Registered pulse line |
| busy | output | 1 | High while a burst is in progress |
| burst_done | output | 1 | One-cycle flag at the end of a burst |

## Verification
Two fixed words are used to check each slot type on its own. An all-zero word leaves only the timing pulses, which checks their spacing and width. An all-ones word fills every slot, which exposes any slot that is skipped or doubled. Single-bit and alternating words show whether the bit order is reversed or shifted by one slot. Random words sent back to back, with requests and word changes thrown in during the burst, show that the word is latched at the start and that the done/busy handover is clean.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic {GEN_IDLE = 1'b0, GEN_RUN = 1'b1} gen_state_e;

  function automatic int unsigned slot_total(input int unsigned bits);
    return 2 * bits + 1;
  endfunction
endpackage

// File: rtl/flp_timebase.sv
module flp_timebase #(
  parameter int unsigned SLOT_TICKS = 6250,
  localparam int unsigned TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          fire,
  output logic          wrap,
  output logic [TW-1:0] tick
);
  // Runs only inside a burst and rests at zero otherwise.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tick <= '0;
    end else if (wrap) begin
      tick <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign fire = run && (tick == '0);
  assign wrap = run && (tick == TW'(SLOT_TICKS - 1));
endmodule

// File: rtl/flp_slot_seq.sv
module flp_slot_seq #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned NPOS = flp_pkg::slot_total(WORD_W),
  localparam int unsigned PW = $clog2(NPOS),
  localparam int unsigned BW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  input  logic              wrap,
  output logic [WORD_W-1:0] word_q,
  output logic              emit,
  output logic              last_slot
);
  logic [PW-1:0] pos;
  logic [BW-1:0] bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      word_q <= '0;
    end else if (start) begin
      pos    <= '0;
      word_q <= word_in;
    end else if (wrap && !last_slot) begin
      pos <= pos + 1'b1;
    end
  end

  // Slot index 0 (and every even index) is a timing slot.
  // Odd index 2k+1 carries bit k.
  always_comb begin
    bidx = BW'(pos >> 1);
    if (!pos[0]) begin
      emit = 1'b1;
    end else begin
      emit = word_q[bidx];
    end
  end

  assign last_slot = (pos == PW'(NPOS - 1));
endmodule

// File: rtl/flp_pulse_shaper.sv
module flp_pulse_shaper #(
  parameter int unsigned PULSE_CYCLES = 10,
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic emit,
  output logic pulse_q
);
  logic [CW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      hold    <= '0;
    end else if (fire) begin
      pulse_q <= emit;
      hold    <= CW'(PULSE_CYCLES - 1);
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen #(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned SLOT_TICKS   = 6250,
  parameter int unsigned PULSE_CYCLES = 10,
  localparam int unsigned TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_req,
  input  logic [WORD_W-1:0] code_word,
  output logic              pulse_out,
  output logic              busy,
  output logic              burst_done
);
  import flp_pkg::*;

  gen_state_e        state;
  logic              start;
  logic              fire;
  logic              wrap;
  logic [TW-1:0]     tick;
  logic [WORD_W-1:0] word_q;
  logic              emit;
  logic              last_slot;
  logic              finish;

  assign busy   = (state == GEN_RUN);
  assign start  = send_req && !busy;
  // The final timing pulse has run its full width.
  assign finish = busy && last_slot && (tick == TW'(PULSE_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= GEN_IDLE;
      burst_done <= 1'b0;
    end else begin
      burst_done <= finish;
      if (start) begin
        state <= GEN_RUN;
      end else if (finish) begin
        state <= GEN_IDLE;
      end
    end
  end

  flp_timebase #(.SLOT_TICKS(SLOT_TICKS)) u_timebase (
    .clk (clk),
    .rst (rst),
    .run (busy),
    .fire(fire),
    .wrap(wrap),
    .tick(tick)
  );

  flp_slot_seq #(.WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .word_in  (code_word),
    .wrap     (wrap),
    .word_q   (word_q),
    .emit     (emit),
    .last_slot(last_slot)
  );

  flp_pulse_shaper #(.PULSE_CYCLES(PULSE_CYCLES)) u_shaper (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .emit   (emit),
    .pulse_q(pulse_out)
  );
endmodule

// File: rtl/flp_burst_gen_chk.sv
module flp_burst_gen_chk #(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned PULSE_CYCLES = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              send_req,
  input logic              pulse_out,
  input logic              busy,
  input logic              burst_done,
  input logic [WORD_W-1:0] word_q
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !pulse_out) begin
      run_len <= 0;
    end else begin
      run_len <= run_len + 1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pulse_out);

  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (send_req && !busy) |=> busy);

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_out) |-> (run_len == PULSE_CYCLES));

  a_r6_word_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(word_q));

  a_r7_handover: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_done) |-> $fell(busy));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);
endmodule

bind flp_burst_gen flp_burst_gen_chk #(
  .WORD_W      (WORD_W),
  .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .send_req  (send_req),
  .pulse_out (pulse_out),
  .busy      (busy),
  .burst_done(burst_done),
  .word_q    (word_q)
);

// File: tb/flp_burst_gen_test.sv
module flp_burst_gen_test;
  localparam int unsigned S = 8;
  localparam int unsigned P = 3;
  localparam int unsigned END_N = 1 + 32 * S + P;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        send_req = 1'b0;
  logic [15:0] code_word = '0;
  logic        pulse_out, busy, burst_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flp_burst_gen #(.WORD_W(16), .SLOT_TICKS(S), .PULSE_CYCLES(P)) uut (
    .clk(clk), .rst(rst), .send_req(send_req), .code_word(code_word),
    .pulse_out(pulse_out), .busy(busy), .burst_done(burst_done)
  );

  // Expected pulse level at the negedge n cycles after the accepting edge.
  function automatic bit exp_pulse(input logic [15:0] w, input int n);
    int m, slot, off;
    if (n < 1) return 1'b0;
    m = n - 1;
    slot = m / S;
    off = m % S;
    if (slot > 32 || off >= P) return 1'b0;
    if (slot % 2 == 0) return 1'b1;   // R3 timing slot
    return w[(slot - 1) / 2];         // R4 data slot, LSB first
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the negedge where burst_done is high.
  task automatic run_burst(input logic [15:0] w, input bit spam);
    send_req = 1'b1;
    code_word = w;
    @(negedge clk);
    send_req = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    check(pulse_out == 1'b0, "R2 no pulse on accept cycle", pulse_out, 0);
    for (int n = 1; n <= END_N; n++) begin
      if (spam && n < END_N) begin
        send_req = 1'($urandom);
        code_word = 16'($urandom);
      end else begin
        send_req = 1'b0;
      end
      @(negedge clk);
      check(pulse_out == exp_pulse(w, n), spam ? "R6 pulse pattern" : "R3/R4/R5 pulse pattern",
            pulse_out, exp_pulse(w, n));
      check(busy == (n < END_N), "R7 busy", busy, (n < END_N));
      check(burst_done == (n == END_N), "R8 done", burst_done, (n == END_N));
    end
    send_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0f1a));
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0 && busy == 1'b0 && burst_done == 1'b0, "R1 reset state",
          {pulse_out, busy, burst_done}, 0);
    rst = 1'b0;
    code_word = 16'hBEEF;
    repeat (4) begin
      @(negedge clk);
      check(pulse_out == 1'b0 && busy == 1'b0, "R1 idle quiet", {pulse_out, busy}, 0);
    end
    run_burst(16'h0000, 1'b0);
    @(negedge clk);
    check(burst_done == 1'b0, "R8 done one cycle", burst_done, 0);
    run_burst(16'hFFFF, 1'b0);
    @(negedge clk);
    run_burst(16'h0001, 1'b0);
    @(negedge clk);
    run_burst(16'h8000, 1'b0);
    @(negedge clk);
    run_burst(16'hA5C3, 1'b1);
    // R9: back-to-back start in the done cycle
    run_burst(16'h5555, 1'b0);
    run_burst(16'hAAAA, 1'b1);
    for (int i = 0; i < 6; i++) begin
      repeat (int'($urandom_range(0, 2))) @(negedge clk);
      run_burst(16'($urandom), (i % 2) == 1);
    end
    @(negedge clk);
    check(busy == 1'b0 && pulse_out == 1'b0, "R1 idle after bursts", {busy, pulse_out}, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule